// File: doc/BRIEF.md
# SPI Frame-Validated Command and Status Port

This block is the serial control port of a four-channel output controller. A host lowers chip select, clocks in one or more 16-bit command words, and raises chip select again. While it clocks, the block returns a 16-bit status word, most significant bit first. Once those 16 bits are out, the block sends back the bits it has received on its data input, so several devices can share one chain and the host can confirm what it sent.

When chip select rises, the block checks the number of clock edges seen during the frame. It accepts the frame only when that count is a nonzero multiple of sixteen. The last sixteen bits received then form the command. The block issues it on a one-cycle register-write strobe and keeps its watchdog and address fields for the next status word. One address acts as the status-select register, and its data bits choose which four-bit diagnostic nibble the status word carries. A frame that is rejected leaves nothing behind: no write, no new select, no cleared flags.

All port inputs are sampled in the system clock domain, so the serial clock must run well below the system clock. Fault and supply flags are sticky from one accepted frame to the next.

Top module: `spi_frame_regif`

## Requirements
- R1: At chip-select rise, a frame of N serial-clock rising edges is accepted exactly when N is nonzero and N mod 16 = 0. An accepted frame gives one `reg_wr_en` pulse, one system clock long. `reg_wr_addr` carries bits 12:8 and `reg_wr_data` carries bits 7:0 of the last 16 bits received, counting bit 15 as the first of those 16 to arrive.
- R2: A rejected frame (0, 15, 17 bits and so on) gives no write strobe. It also leaves the stored command fields, the select setting and the sticky flags unchanged, so the next frame reports the same status as if the rejected frame had not happened.
- R3: During a frame, `spi_dout` first presents status bits 15 down to 0. It changes after serial-clock falling edges, and the first bit is valid once chip select has fallen. From the 17th bit on, it repeats the bits received on `spi_din`, starting with the first bit of the frame.
- R4: `spi_dout_en` is 1 while chip select is low and 0 while it is high, including after reset.
- R5: Status bit 15 is bit 15 (watchdog) of the last accepted command, and status bits 12:8 are that command's address field. Both read 0 after reset.
- R6: Status bit 14 is set if `uv_in` was high at any clock since the last accepted frame ended, and status bit 13 does the same for `ov_in`. The end of an accepted frame reloads both flags from the current inputs.
- R7: Status bits 7:4 are sticky fault flags for channels 3, 2, 1, 0 in that order. They are set by `chan_fault[3:0]` and reloaded from the inputs at the end of an accepted frame.
- R8: An accepted command whose address equals SEL_ADDR (default 5'h10) loads the select setting from its data bits 4:0. `diag_src` takes data bits 2:0 and `diag_ch` takes data bits 4:3. No other event changes them, and both are 0 after reset. Status bits 3:0 are `diag_data`.
- R9: The status word is captured when chip select falls. Flag events that arrive during a frame do not appear in that frame's status, but they do appear in the next frame's status when the current frame is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_din | input | 1 | Serial data into the block |
| spi_dout | output | 1 | Serial data out of the block |
| spi_dout_en | output | 1 | Drive enable for the `spi_dout` pad (0 = high impedance) |
| reg_wr_en | output | 1 | One-cycle write strobe for an accepted command |
| reg_wr_addr | output | 5 | Address field of the accepted command |
| reg_wr_data | output | 8 | Data field of the accepted command |
| chan_fault | input | 4 | Per-channel fault indications |
| uv_in | input | 1 | Supply under-voltage indication |
| ov_in | input | 1 | Supply over-voltage indication |
| diag_src | output | 3 | Selected diagnostic source |
| diag_ch | output | 2 | Selected channel for channel-specific diagnostics |
| diag_data | input | 4 | Diagnostic nibble returned for the current selection |

## Verification
The hardest case to reach is the proof that a rejected frame leaves no trace. The effect can only be seen one frame later, through the status word. The bench therefore sweeps frame lengths from 0 to 34 bits and follows every rejected length with a frame whose status it predicts from its own model of the last accepted command, the select setting and the sticky flags. It also raises a fault in the middle of a rejected frame, to show that the flag was held back from that frame's status but is reported in the next one.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int NCH    = 4;
  localparam int DIAG_W = 4;

  typedef struct packed {
    logic              wd;
    logic [1:0]        spare;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic              wd;
    logic              uv;
    logic              ov;
    logic [ADDR_W-1:0] addr;
    logic [NCH-1:0]    flt;
    logic [DIAG_W-1:0] diag;
  } status_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] pipe [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_regif_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_low,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              din,
  input  logic [WORD_W-1:0] status_i,
  output logic              dout,
  output logic              dout_en,
  output logic              frame_end,
  output logic              frame_ok,
  output logic [WORD_W-1:0] frame_cmd
);
  localparam int LOW_W = $clog2(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      nbits     <= '0;
      dout      <= 1'b0;
      dout_en   <= 1'b0;
      frame_end <= 1'b0;
      frame_ok  <= 1'b0;
      frame_cmd <= '0;
    end else begin
      dout_en   <= cs_low;
      frame_end <= cs_rise;
      if (cs_fall) begin
        shreg <= status_i;
        dout  <= status_i[WORD_W-1];
        nbits <= '0;
      end else if (cs_low) begin
        if (sck_rise) begin
          shreg <= {shreg[WORD_W-2:0], din};
          if (nbits != '1) nbits <= nbits + 1'b1;
        end
        if (sck_fall) dout <= shreg[WORD_W-1];
      end
      if (cs_rise) begin
        frame_ok  <= (nbits != '0) && (nbits[LOW_W-1:0] == '0);
        frame_cmd <= shreg;
      end
    end
  end
endmodule

// File: rtl/spi_status_ctl.sv
module spi_status_ctl
  import spi_regif_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SEL_ADDR = 5'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              frame_ok,
  input  logic [WORD_W-1:0] frame_cmd,
  input  logic [NCH-1:0]    chan_fault,
  input  logic              uv_in,
  input  logic              ov_in,
  input  logic [DIAG_W-1:0] diag_data,
  output logic [WORD_W-1:0] status_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [2:0]        sel_src,
  output logic [1:0]        sel_ch
);
  cmd_t              cmd;
  status_t           st;
  logic              last_wd;
  logic [ADDR_W-1:0] last_addr;
  logic              uv_st, ov_st;
  logic [NCH-1:0]    flt_st;

  assign cmd = cmd_t'(frame_cmd);

  always_comb begin
    st.wd    = last_wd;
    st.uv    = uv_st;
    st.ov    = ov_st;
    st.addr  = last_addr;
    st.flt   = flt_st;
    st.diag  = diag_data;
    status_o = st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_wd   <= 1'b0;
      last_addr <= '0;
      uv_st     <= 1'b0;
      ov_st     <= 1'b0;
      flt_st    <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      sel_src   <= '0;
      sel_ch    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (frame_end && frame_ok) begin
        last_wd   <= cmd.wd;
        last_addr <= cmd.addr;
        wr_en     <= 1'b1;
        wr_addr   <= cmd.addr;
        wr_data   <= cmd.data;
        if (cmd.addr == SEL_ADDR) begin
          sel_src <= cmd.data[2:0];
          sel_ch  <= cmd.data[4:3];
        end
        uv_st  <= uv_in;
        ov_st  <= ov_in;
        flt_st <= chan_fault;
      end else begin
        uv_st  <= uv_st | uv_in;
        ov_st  <= ov_st | ov_in;
        flt_st <= flt_st | chan_fault;
      end
    end
  end
endmodule

// File: rtl/spi_frame_regif.sv
module spi_frame_regif
  import spi_regif_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                CNT_W       = 7,
  parameter logic [ADDR_W-1:0] SEL_ADDR    = 5'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_din,
  output logic              spi_dout,
  output logic              spi_dout_en,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  input  logic [NCH-1:0]    chan_fault,
  input  logic              uv_in,
  input  logic              ov_in,
  output logic [2:0]        diag_src,
  output logic [1:0]        diag_ch,
  input  logic [DIAG_W-1:0] diag_data
);
  localparam int IX_SCK = 0;
  localparam int IX_CS  = 1;
  localparam int IX_DIN = 2;

  logic [2:0]        s_lvl, s_rise, s_fall;
  logic              frame_end, frame_ok;
  logic [WORD_W-1:0] frame_cmd, status_w;

  spi_edge_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk (clk),
    .rst (rst),
    .din ({spi_din, spi_cs_n, spi_sck}),
    .lvl (s_lvl),
    .rise(s_rise),
    .fall(s_fall)
  );

  spi_frame_shifter #(.CNT_W(CNT_W)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .cs_low   (~s_lvl[IX_CS]),
    .cs_fall  (s_fall[IX_CS]),
    .cs_rise  (s_rise[IX_CS]),
    .sck_rise (s_rise[IX_SCK]),
    .sck_fall (s_fall[IX_SCK]),
    .din      (s_lvl[IX_DIN]),
    .status_i (status_w),
    .dout     (spi_dout),
    .dout_en  (spi_dout_en),
    .frame_end(frame_end),
    .frame_ok (frame_ok),
    .frame_cmd(frame_cmd)
  );

  spi_status_ctl #(.SEL_ADDR(SEL_ADDR)) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .frame_ok  (frame_ok),
    .frame_cmd (frame_cmd),
    .chan_fault(chan_fault),
    .uv_in     (uv_in),
    .ov_in     (ov_in),
    .diag_data (diag_data),
    .status_o  (status_w),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .sel_src   (diag_src),
    .sel_ch    (diag_ch)
  );
endmodule

// File: rtl/spi_frame_regif_chk.sv
module spi_frame_regif_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_en,
  input logic        spi_dout_en,
  input logic [2:0]  diag_src,
  input logic [1:0]  diag_ch,
  input logic        frame_end,
  input logic        frame_ok,
  input logic        uv_in,
  input logic        ov_in,
  input logic [3:0]  chan_fault,
  input logic [15:0] status_word
);
  // R1
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  // R2
  reject_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !frame_ok) |=> !reg_wr_en);

  // R4
  released_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !spi_dout_en);

  // R6
  uv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    uv_in |=> status_word[14]);

  // R6
  ov_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ov_in |=> status_word[13]);

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|chan_fault) |=> ((status_word[7:4] & $past(chan_fault)) == $past(chan_fault)));

  // R8
  select_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_en |-> $stable({diag_ch, diag_src}));
endmodule

bind spi_frame_regif spi_frame_regif_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .reg_wr_en  (reg_wr_en),
  .spi_dout_en(spi_dout_en),
  .diag_src   (diag_src),
  .diag_ch    (diag_ch),
  .frame_end  (frame_end),
  .frame_ok   (frame_ok),
  .uv_in      (uv_in),
  .ov_in      (ov_in),
  .chan_fault (chan_fault),
  .status_word(status_w)
);

// File: tb/spi_frame_regif_tb_top.sv
module spi_frame_regif_tb_top;
  localparam int HALF = 8;
  localparam logic [4:0] SEL = 5'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_din = 1'b0;
  logic spi_dout, spi_dout_en, reg_wr_en;
  logic [4:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic [3:0] chan_fault = '0;
  logic uv_in = 1'b0, ov_in = 1'b0;
  logic [2:0] diag_src;
  logic [1:0] diag_ch;
  logic [3:0] diag_data;

  int checks = 0, fails = 0;
  int wr_cnt = 0;
  logic [4:0] wr_addr_seen = '0;
  logic [7:0] wr_data_seen = '0;

  // bench model
  logic m_wd = 1'b0, m_uv = 1'b0, m_ov = 1'b0;
  logic [4:0] m_addr = '0, m_sel = '0;
  logic [3:0] m_flt = '0;

  always #5 clk = ~clk;

  assign diag_data = {diag_ch, diag_src[1:0]} ^ 4'h5;

  spi_frame_regif dut_i (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_din(spi_din),
    .spi_dout(spi_dout), .spi_dout_en(spi_dout_en), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .chan_fault(chan_fault),
    .uv_in(uv_in), .ov_in(ov_in), .diag_src(diag_src), .diag_ch(diag_ch),
    .diag_data(diag_data)
  );

  always @(posedge clk) begin
    if (!rst && reg_wr_en) begin
      wr_cnt       <= wr_cnt + 1;
      wr_addr_seen <= reg_wr_addr;
      wr_data_seen <= reg_wr_data;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_status();
    return {m_wd, m_uv, m_ov, m_addr, m_flt, ({m_sel[4:3], m_sel[1:0]} ^ 4'h5)};
  endfunction

  task automatic pulse_flags(input logic uv, input logic ov, input logic [3:0] f);
    uv_in = uv; ov_in = ov; chan_fault = f;
    tick(3);
    uv_in = 1'b0; ov_in = 1'b0; chan_fault = '0;
    tick(2);
    m_uv |= uv; m_ov |= ov; m_flt |= f;
  endtask

  // send n bits, MSB (bits[n-1]) first; mid=1 raises a channel 2 fault inside the frame
  task automatic frame(input int n, input logic [63:0] bits, input bit mid);
    logic [63:0] got, exp;
    logic [15:0] st;
    int wr0;
    bit ok;
    got = '0; exp = '0;
    st  = model_status();
    wr0 = wr_cnt;
    spi_cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      got[i] = spi_dout;
      exp[i] = (i < 16) ? st[15-i] : bits[n-1-(i-16)];
      if (i == 0) chk(spi_dout_en == 1'b1, "R4 drive low-cs", {63'd0, spi_dout_en}, 64'd1);
      if (mid && i == 3) begin
        chan_fault = 4'b0100; tick(2); chan_fault = '0;
      end
      spi_din = bits[n-1-i];
      spi_sck = 1'b1; tick(HALF);
      spi_sck = 1'b0; tick(HALF);
    end
    spi_cs_n = 1'b1;
    tick(HALF);
    chk(spi_dout_en == 1'b0, "R4 release", {63'd0, spi_dout_en}, 64'd0);
    tick(HALF);
    if (n > 0) chk(got == exp, "R3 serial out", got, exp);
    ok = (n != 0) && (n % 16 == 0);
    if (ok) begin
      chk(wr_cnt == wr0 + 1 && wr_addr_seen == bits[12:8] && wr_data_seen == bits[7:0],
          "R1 accepted write", {wr_cnt[15:0], 3'd0, wr_addr_seen, wr_data_seen},
          {wr0[15:0] + 16'd1, 3'd0, bits[12:8], bits[7:0]});
      m_wd = bits[15]; m_addr = bits[12:8];
      if (bits[12:8] == SEL) m_sel = bits[4:0];
      m_uv = 1'b0; m_ov = 1'b0; m_flt = '0;
    end else begin
      chk(wr_cnt == wr0, "R2 rejected no write", wr_cnt, wr0);
      if (mid) m_flt |= 4'b0100;
    end
    chk({diag_ch, diag_src} == m_sel, "R8 select", {diag_ch, diag_src}, m_sel);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(4);
    // reset state
    chk(spi_dout_en == 1'b0, "R4 reset", spi_dout_en, 0);
    chk(reg_wr_en == 1'b0, "R1 reset strobe", reg_wr_en, 0);
    chk({diag_ch, diag_src} == 5'd0, "R8 reset select", {diag_ch, diag_src}, 0);

    // R5: status shows zeros after reset, then previous command fields
    frame(16, 64'h8000 | 64'h035A, 0);
    frame(16, {48'd0, 1'b0, 2'b11, SEL, 8'b0001_0011}, 0);   // R8 select src 3 ch 2
    chk(diag_src == 3'd3 && diag_ch == 2'd2, "R8 select fields", {diag_ch, diag_src}, 5'b10011);

    // R2: 15, 17 and 0 bit frames leave no trace
    frame(15, 64'h7FFF, 0);
    frame(17, 64'h1_A5C3, 0);
    frame(0, 64'd0, 0);
    frame(16, 64'h0102, 0);                                    // status checks R5 after rejects

    // R3: 32-bit frame, echo of the first word, write of the second
    frame(32, 64'hC3A5_9F04, 0);

    // R6 / R7: sticky flags survive a rejected frame, clear after an accepted one
    pulse_flags(1'b1, 1'b0, 4'b1000);
    frame(15, 64'h1234, 0);
    frame(16, 64'h0A11, 0);
    frame(16, 64'h0B22, 0);
    pulse_flags(1'b0, 1'b1, 4'b0001);
    frame(17, 64'h0_0F0F, 0);
    frame(16, 64'h9C33, 0);

    // R9: fault during a rejected frame appears only in the next frame
    frame(15, 64'h2222, 1);
    frame(16, 64'h0444, 0);

    // R8: select retained across writes to other addresses, new select replaces it
    frame(16, {48'd0, 3'b000, SEL, 8'b0000_1101}, 0);
    frame(16, 64'h0555, 0);

    // R1 / R2 / R3: frame length sweep 0..34
    for (int n = 0; n <= 34; n++) begin
      logic [63:0] pat;
      pat = {64'h9E37_79B9_7F4A_7C15} ^ (64'h0123_4567_89AB_CDEF << n) ^ n;
      frame(n, pat, 0);
    end

    // R5 / R8: every address with alternating watchdog bit
    for (int a = 0; a < 32; a++) begin
      logic [15:0] w;
      w = {a[0], 2'b01, a[4:0], a[7:0] ^ 8'h6C};
      frame(16, {48'd0, w}, 0);
    end
    frame(16, 64'h0000, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule